// File: doc/BRIEF.md
# Converter Readout Sequencer

This block drives a delta-sigma converter that runs in single-cycle settling mode and collects each 24-bit result. It issues a start request to the converter and then waits for the data-ready line to go from low to high. It then produces a serial clock and shifts the result in from the converter's serial data line, most significant bit first. Each finished word appears on a parallel output, and a valid strobe marks it for one cycle.

There are two operating modes. In pulsed mode the start line goes high for a fixed number of system cycles, once per conversion. It is raised again only after the whole 24-bit readout has finished, because a new start request during settling throws away the conversion in progress. The time between results is therefore the settling time plus the readout time. In continuous mode the start line stays high and the block services every data-ready rising edge, so a new result arrives once per settling period.

The run request, the mode select and the serial clock divider are taken only while the sequencer is idle. In continuous mode the run request is also checked at the end of each readout. If it is low at that point, start drops and the block returns to idle.

Top module: `cnv_readout_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, start_o, sclk_o and word_vld_o are low and word_o is zero.
- R2: In pulsed mode, start_o is high for exactly START_W consecutive system cycles per conversion and then goes low.
- R3: In pulsed mode, start_o does not rise again between the end of a start pulse and the valid strobe of that conversion's readout.
- R4: sclk_o stays low until a rising edge of drdy_i has passed the SYNC_N-stage synchronizer. While drdy_i stays low after a start, no readout begins.
- R5: A readout has exactly 24 serial clock periods. Each period has a low phase and a high phase, each lasting D system cycles, where D is sclk_div_i and a value of 0 counts as 1. dout_i is sampled as sclk_o goes high, and the first bit sampled becomes bit 23 of word_o.
- R6: word_vld_o is high for exactly one cycle when the 24th serial clock period ends. word_o keeps that word after the strobe.
- R7: In continuous mode, start_o rises once and stays high across readouts. Every data-ready rising edge that arrives while the block is waiting produces one word.
- R8: In continuous mode, if run_i is low when a readout completes, start_o goes low within two cycles after the valid strobe and no further readout starts.
- R9: A change to cont_mode_i or sclk_div_i while a conversion is in progress does not affect that conversion: start_o stays low in pulsed mode and the serial clock keeps the divider value latched at start.
- R10: In pulsed mode with run_i high, the next start pulse follows the valid strobe. With run_i low at that point, start_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Run request |
| cont_mode_i | input | 1 | 1 selects continuous mode, 0 selects pulsed mode |
| sclk_div_i | input | 8 | Serial clock half-period in system cycles (0 is treated as 1) |
| drdy_i | input | 1 | Converter data-ready line (asynchronous) |
| dout_i | input | 1 | Converter serial data |
| start_o | output | 1 | Conversion start request to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| word_o | output | 24 | Last captured conversion word |
| word_vld_o | output | 1 | One-cycle strobe for a new word |

## Verification
A control state that leaves the wait phase too early shows up at once as a start edge while a conversion is in flight, or as serial clock activity before any data-ready edge. Both can be seen within one cycle of the fault. A fault in the bit counter or the divider changes the number of serial clock periods, or the length of a high phase, before the strobe. It also changes the captured word, which is compared against the pattern the bench sent, so the error appears at the next strobe at the latest. A latched configuration that follows its input during a conversion shows up as a rising start line or a wrong high-phase length within the same readout.

// File: rtl/cnv_seq_pkg.sv
package cnv_seq_pkg;

    localparam int unsigned CNV_WORD_W = 24;
    localparam int unsigned CNV_DIV_W  = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_PULSE,
        SEQ_WAIT,
        SEQ_SHIFT
    } seq_state_e;

    // configuration latched when a run begins
    typedef struct packed {
        logic                 cont;
        logic [CNV_DIV_W-1:0] div;
    } seq_cfg_t;

    // captured result with its strobe
    typedef struct packed {
        logic [CNV_WORD_W-1:0] data;
        logic                  valid;
    } rx_word_t;

    // half period of the serial clock, never below one cycle
    function automatic logic [CNV_DIV_W-1:0] half_period(input logic [CNV_DIV_W-1:0] d);
        return (d == '0) ? CNV_DIV_W'(1) : d;
    endfunction

endpackage

// File: rtl/cnv_rdy_sync.sv
module cnv_rdy_sync #(
    parameter int unsigned SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rdy_async,
    output logic rdy_rise
);

    logic [SYNC_N-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[SYNC_N-2:0], rdy_async};
            last  <= chain[SYNC_N-1];
        end
    end

    assign rdy_rise = chain[SYNC_N-1] & ~last;

endmodule

// File: rtl/cnv_seq_ctrl.sv
module cnv_seq_ctrl
    import cnv_seq_pkg::*;
#(
    parameter int unsigned START_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 cont_sel,
    input  logic [CNV_DIV_W-1:0] div_sel,
    input  logic                 rdy_rise,
    input  logic                 rd_done,
    output logic                 start,
    output logic                 go,
    output seq_cfg_t             cfg
);

    localparam int unsigned PCNT_W = (START_W < 2) ? 1 : $clog2(START_W + 1);

    seq_state_e         st;
    logic [PCNT_W-1:0]  pcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SEQ_IDLE;
            start <= 1'b0;
            go    <= 1'b0;
            pcnt  <= '0;
            cfg   <= '0;
        end else begin
            go <= 1'b0;
            unique case (st)
                SEQ_IDLE: begin
                    if (run) begin
                        cfg.cont <= cont_sel;
                        cfg.div  <= div_sel;
                        start    <= 1'b1;
                        pcnt     <= PCNT_W'(START_W - 1);
                        st       <= cont_sel ? SEQ_WAIT : SEQ_PULSE;
                    end
                end
                SEQ_PULSE: begin
                    if (pcnt == '0) begin
                        start <= 1'b0;
                        st    <= SEQ_WAIT;
                    end else begin
                        pcnt <= pcnt - 1'b1;
                    end
                end
                SEQ_WAIT: begin
                    if (rdy_rise) begin
                        go <= 1'b1;
                        st <= SEQ_SHIFT;
                    end
                end
                SEQ_SHIFT: begin
                    if (rd_done) begin
                        if (cfg.cont && run) begin
                            st <= SEQ_WAIT;
                        end else begin
                            start <= 1'b0;
                            st    <= SEQ_IDLE;
                        end
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cnv_shift_rx.sv
module cnv_shift_rx
    import cnv_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic [CNV_DIV_W-1:0] div,
    input  logic                 sdata,
    output logic                 sclk,
    output rx_word_t             rx
);

    localparam int unsigned NB_W = $clog2(CNV_WORD_W + 1);

    logic                  active;
    logic [CNV_DIV_W-1:0]  cnt;
    logic [NB_W-1:0]       nbit;
    logic [CNV_WORD_W-1:0] shreg;
    logic [CNV_DIV_W-1:0]  reload;

    assign reload = half_period(div) - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sclk   <= 1'b0;
            cnt    <= '0;
            nbit   <= '0;
            shreg  <= '0;
            rx     <= '0;
        end else begin
            rx.valid <= 1'b0;
            if (go && !active) begin
                active <= 1'b1;
                sclk   <= 1'b0;
                cnt    <= reload;
                nbit   <= '0;
            end else if (active) begin
                if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else begin
                    cnt <= reload;
                    if (!sclk) begin
                        sclk  <= 1'b1;
                        shreg <= {shreg[CNV_WORD_W-2:0], sdata};
                        nbit  <= nbit + 1'b1;
                    end else begin
                        sclk <= 1'b0;
                        if (nbit == NB_W'(CNV_WORD_W)) begin
                            active   <= 1'b0;
                            rx.data  <= shreg;
                            rx.valid <= 1'b1;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cnv_readout_seq.sv
module cnv_readout_seq
    import cnv_seq_pkg::*;
#(
    parameter int unsigned START_W = 2,
    parameter int unsigned SYNC_N  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run_i,
    input  logic                  cont_mode_i,
    input  logic [CNV_DIV_W-1:0]  sclk_div_i,
    input  logic                  drdy_i,
    input  logic                  dout_i,
    output logic                  start_o,
    output logic                  sclk_o,
    output logic [CNV_WORD_W-1:0] word_o,
    output logic                  word_vld_o
);

    logic     rdy_rise;
    logic     rd_go;
    seq_cfg_t cfg;
    rx_word_t rx;

    cnv_rdy_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .rdy_async (drdy_i),
        .rdy_rise  (rdy_rise)
    );

    cnv_seq_ctrl #(.START_W(START_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .run      (run_i),
        .cont_sel (cont_mode_i),
        .div_sel  (sclk_div_i),
        .rdy_rise (rdy_rise),
        .rd_done  (rx.valid),
        .start    (start_o),
        .go       (rd_go),
        .cfg      (cfg)
    );

    cnv_shift_rx u_rx (
        .clk   (clk),
        .rst   (rst),
        .go    (rd_go),
        .div   (cfg.div),
        .sdata (dout_i),
        .sclk  (sclk_o),
        .rx    (rx)
    );

    assign word_o     = rx.data;
    assign word_vld_o = rx.valid;

endmodule

// File: rtl/cnv_seq_chk.sv
module cnv_seq_chk #(
    parameter int unsigned START_W = 2,
    parameter int unsigned WORD_W  = 24
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic sclk,
    input logic vld,
    input logic rdy_rise
);

    logic       busy;
    logic       armed;
    logic       start_d;
    logic       sclk_d;
    logic [7:0] hi_cnt;
    logic [7:0] rises;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            armed   <= 1'b0;
            start_d <= 1'b0;
            sclk_d  <= 1'b0;
            hi_cnt  <= '0;
            rises   <= '0;
        end else begin
            start_d <= start;
            sclk_d  <= sclk;
            if (start && !start_d) busy <= 1'b1;
            else if (vld)          busy <= 1'b0;
            if (rdy_rise)  armed <= 1'b1;
            else if (vld)  armed <= 1'b0;
            if (!start)              hi_cnt <= '0;
            else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 1'b1;
            if (vld)                 rises <= '0;
            else if (sclk && !sclk_d) rises <= rises + 1'b1;
        end
    end

    // R2: a start pulse is never shorter than START_W cycles
    a_r2_pulse_width: assert property (@(posedge clk) disable iff (rst)
        $fell(start) |-> (hi_cnt >= 8'(START_W)));

    // R3: no new start edge while a conversion is still unread
    a_r3_no_early_start: assert property (@(posedge clk) disable iff (rst)
        $rose(start) |-> !busy);

    // R4: serial clock runs only after a synchronized data-ready edge
    a_r4_sclk_after_ready: assert property (@(posedge clk) disable iff (rst)
        sclk |-> armed);

    // R5: exactly WORD_W serial clock periods per word
    a_r5_bit_count: assert property (@(posedge clk) disable iff (rst)
        vld |-> (rises == 8'(WORD_W)));

    // R6: strobe lasts one cycle
    a_r6_strobe_single: assert property (@(posedge clk) disable iff (rst)
        vld |=> !vld);

    // R6: strobe arrives with the serial clock back low
    a_r6_strobe_sclk_low: assert property (@(posedge clk) disable iff (rst)
        vld |-> !sclk);

endmodule

bind cnv_readout_seq cnv_seq_chk #(.START_W(START_W), .WORD_W(CNV_WORD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start_o),
    .sclk     (sclk_o),
    .vld      (word_vld_o),
    .rdy_rise (rdy_rise)
);

// File: tb/sim_cnv_readout_seq.sv
module sim_cnv_readout_seq;
    import cnv_seq_pkg::*;

    localparam int START_W = 2;
    localparam int SETTLE  = 20;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  run = 1'b0;
    logic                  cont = 1'b0;
    logic                  drdy = 1'b0;
    logic [CNV_DIV_W-1:0]  div = '0;
    logic                  dout;
    logic                  start_o, sclk_o, vld;
    logic [CNV_WORD_W-1:0] word;

    int n_chk = 0;
    int n_fail = 0;
    int fall_cnt = 0;
    int base = 0;
    int exp_div = 1;
    int off;
    logic [23:0] cur_w = '0;

    always #5 clk = ~clk;

    // converter model: advance one bit on every serial clock fall
    always @(negedge sclk_o) fall_cnt++;
    always_comb off = fall_cnt - base;
    assign dout = (off >= 0 && off < 24) ? cur_w[23 - off] : 1'b0;

    cnv_readout_seq #(.START_W(START_W)) u0 (
        .clk         (clk),
        .rst         (rst),
        .run_i       (run),
        .cont_mode_i (cont),
        .sclk_div_i  (div),
        .drdy_i      (drdy),
        .dout_i      (dout),
        .start_o     (start_o),
        .sclk_o      (sclk_o),
        .word_o      (word),
        .word_vld_o  (vld)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_start(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (start_o) begin
                seen = 1'b1;
                return;
            end
            @(negedge clk);
        end
    endtask

    task automatic conv(input logic [23:0] w, input bit pulsed, input bit poke, input bit stop_now);
        int hi = 0;
        int rises = 0;
        bit prev = 1'b0;
        bit got = 1'b0;
        logic [CNV_DIV_W-1:0] save_div;
        string stag;
        stag = pulsed ? (poke ? "R9 start held low despite mode change" : "R3 start low during settling")
                      : "R7 start held high";
        save_div = div;
        for (int i = 0; i < SETTLE; i++) begin
            @(negedge clk);
            chk(sclk_o == 1'b0, "R4 sclk low before data-ready", sclk_o, 0);
            chk(start_o == !pulsed, stag, start_o, !pulsed);
            if (poke && i == 2) begin
                cont = 1'b1;
                div  = div + 5;
            end
            if (poke && i == SETTLE - 3) begin
                cont = 1'b0;
                div  = save_div;
            end
        end
        if (stop_now) run = 1'b0;
        cur_w = w;
        base  = fall_cnt;
        drdy  = 1'b1;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (sclk_o) begin
                if (!prev) rises++;
                hi++;
            end else if (hi > 0) begin
                chk(hi == exp_div, poke ? "R9 latched divider kept" : "R5 high phase length", hi, exp_div);
                hi = 0;
            end
            prev = sclk_o;
            if (!vld) chk(start_o == !pulsed, stag, start_o, !pulsed);
            if (vld) begin
                got = 1'b1;
                break;
            end
        end
        chk(got, "R6 valid strobe seen", got, 1);
        chk(word == w, "R5 captured word", word, w);
        chk(rises == 24, "R5 serial clock periods", rises, 24);
        @(negedge clk);
        chk(vld == 1'b0, "R6 strobe single cycle", vld, 0);
        chk(word == w, "R6 word held", word, w);
        drdy = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
        $finish;
    end

    initial begin
        bit seen;
        int wdt;
        logic [23:0] w;

        @(negedge clk);
        @(negedge clk);
        chk(start_o == 1'b0, "R1 start in reset", start_o, 0);
        chk(sclk_o == 1'b0, "R1 sclk in reset", sclk_o, 0);
        chk(vld == 1'b0, "R1 valid in reset", vld, 0);
        chk(word == '0, "R1 word in reset", word, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(start_o == 1'b0 && sclk_o == 1'b0 && vld == 1'b0, "R1 idle after reset",
            {start_o, sclk_o, vld}, 0);

        for (int d = 0; d < 4; d++) begin
            // pulsed mode sweep
            div     = CNV_DIV_W'(d);
            exp_div = (d == 0) ? 1 : d;
            cont    = 1'b0;
            run     = 1'b1;
            for (int k = 0; k < 5; k++) begin
                case (k)
                    0: w = 24'h800000;
                    1: w = 24'h000001;
                    2: w = 24'hFFFFFF;
                    default: w = 24'((d * 24'h13579B + k * 24'h2468AC) ^ 24'hA5A5A5);
                endcase
                wait_start(seen);
                chk(seen, "R10 next start after readout", seen, 1);
                wdt = 0;
                while (start_o && wdt < 50) begin
                    wdt++;
                    @(negedge clk);
                end
                chk(wdt == START_W, "R2 start pulse width", wdt, START_W);
                conv(w, 1'b1, k == 2, k == 4);
            end
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                chk(start_o == 1'b0, "R10 no start after stop", start_o, 0);
            end

            // continuous mode sweep
            cont = 1'b1;
            run  = 1'b1;
            wait_start(seen);
            chk(seen, "R7 start raised in continuous mode", seen, 1);
            for (int k = 0; k < 4; k++) begin
                w = 24'((d + 1) * 24'h0F1E2D + k * 24'h3C4B5A);
                conv(w, 1'b0, 1'b0, k == 3);
            end
            @(negedge clk);
            chk(start_o == 1'b0, "R8 start dropped after stop", start_o, 0);
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                chk(start_o == 1'b0 && sclk_o == 1'b0, "R8 stays idle after stop",
                    {start_o, sclk_o}, 0);
            end
            cont = 1'b0;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule